// File: doc/BRIEF.md
# Parity-Checked Pixel Payload Recirculator

This block sits behind a pixel-link receiver. On every pixel clock it takes one payload that has already been deserialized. A payload holds red, green and blue colour words, the data-enable and the two sync controls, a 2-bit rolling sequence count and one parity bit. The block checks the parity of each payload and follows the sequence count, so that it knows when the stream can be trusted. Trusted payloads go to a registered parallel colour and control output.

When a payload is corrupt or out of order, it is dropped. The output keeps repeating the last trusted payload until the stream proves itself again, and an error flag stays high for each cycle of repetition. Until the stream has been trusted for the first time, the output stays blank.

A mode input selects 8 or 6 significant bits per colour. In the narrow mode, the two low bits of each colour are ignored on input and driven low on output.

Top module: `pix_recirc`

## Requirements
- R1: A payload has good parity when the count of ones over the active colour bits, DE, VS, HS, both sequence bits and the parity bit is odd.
- R2: Once the output has been trusted, a payload with bad parity never appears at the output. On the next cycle the output repeats the previous output values unchanged and `err` is 1.
- R3: `err` is a register. It is 1 on every cycle where the output is a repetition and 0 on every cycle where the output comes from the payload of the previous cycle.
- R4: A payload is forwarded one cycle later only when three conditions hold: its parity is good, the payload just before it had good parity, and its sequence value equals the previous payload's value plus one modulo 4 (3 is followed by 0).
- R5: A payload with good parity whose sequence value breaks the increment is treated as an error, in the same way as a parity error.
- R6: From reset until the first forwarded payload, all colour outputs and DE, VS and HS are 0, and `err` is 0.
- R7: With `mode24`=0, only colour bits [7:2] count towards parity. Input bits [1:0] of each colour have no effect, and output bits [1:0] of each colour are 0 on forwarded payloads.
- R8: With `mode24`=1, all 8 bits of each colour count towards parity and are forwarded unchanged.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode24 | input | 1 | 1: 8 bits per colour, 0: 6 bits per colour |
| in_r | input | 8 | Received red |
| in_g | input | 8 | Received green |
| in_b | input | 8 | Received blue |
| in_de | input | 1 | Received data enable |
| in_vs | input | 1 | Received vertical sync |
| in_hs | input | 1 | Received horizontal sync |
| in_seq | input | 2 | Received sequence count (bit 1 is F1, bit 0 is F0) |
| in_par | input | 1 | Received odd-parity bit |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |
| out_de | output | 1 | Output data enable |
| out_vs | output | 1 | Output vertical sync |
| out_hs | output | 1 | Output horizontal sync |
| err | output | 1 | High while the output is a repetition |

## Verification
Every result of this block is due one rising edge after the payload that causes it. This covers a forwarded pixel, a repeated pixel and a change of the error flag. The only state older than that payload is the previous payload's parity verdict and sequence value. The bench applies each payload at a falling edge and compares the whole output word at the next falling edge, before it applies the next payload. Each comparison is against a model state that was advanced when that payload was applied, so every check lines up with exactly one cycle of latency.

// File: rtl/pix_recirc.sv
module pix_recirc #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode24,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic          in_de,
  input  logic          in_vs,
  input  logic          in_hs,
  input  logic [1:0]    in_seq,
  input  logic          in_par,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b,
  output logic          out_de,
  output logic          out_vs,
  output logic          out_hs,
  output logic          err
);

  localparam int DROP = 2;
  localparam int KEEP = CW - DROP;

  logic [CW-1:0] cmask, r_m, g_m, b_m;
  logic          par_ok, prev_ok, started, pass;
  logic [1:0]    prev_seq, seq_exp;

  assign cmask   = mode24 ? {CW{1'b1}} : {{KEEP{1'b1}}, {DROP{1'b0}}};
  assign r_m     = in_r & cmask;
  assign g_m     = in_g & cmask;
  assign b_m     = in_b & cmask;
  assign par_ok  = ^{r_m, g_m, b_m, in_de, in_vs, in_hs, in_seq, in_par};
  assign seq_exp = prev_seq + 2'd1;
  assign pass    = par_ok && prev_ok && (in_seq == seq_exp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ok  <= 1'b0;
      prev_seq <= 2'd0;
      started  <= 1'b0;
      err      <= 1'b0;
      out_r    <= '0;
      out_g    <= '0;
      out_b    <= '0;
      out_de   <= 1'b0;
      out_vs   <= 1'b0;
      out_hs   <= 1'b0;
    end else begin
      prev_ok  <= par_ok;
      prev_seq <= in_seq;
      if (pass) begin
        started <= 1'b1;
        err     <= 1'b0;
        out_r   <= r_m;
        out_g   <= g_m;
        out_b   <= b_m;
        out_de  <= in_de;
        out_vs  <= in_vs;
        out_hs  <= in_hs;
      end else begin
        err <= started;
      end
    end
  end

  // R2 / R3: a repeated cycle leaves every output unchanged
  p_hold_on_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(out_r) && $stable(out_g) && $stable(out_b) &&
             $stable(out_de) && $stable(out_vs) && $stable(out_hs)));

  p_bad_parity_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !par_ok) |=> err);

  p_need_two_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !prev_ok) |=> err);

  p_blank_before_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (out_r == '0 && out_g == '0 && out_b == '0 &&
                  !out_de && !out_vs && !out_hs && !err));

  p_narrow_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(started) && !$past(mode24) && !err && started) |->
      (out_r[DROP-1:0] == '0 && out_g[DROP-1:0] == '0 && out_b[DROP-1:0] == '0));

endmodule

// File: tb/test_pix_recirc.sv
`timescale 1ns/1ps
module test_pix_recirc;
  logic clk = 1'b0;
  logic rst_n;
  logic mode24;
  logic [7:0] in_r, in_g, in_b;
  logic in_de, in_vs, in_hs, in_par;
  logic [1:0] in_seq;
  logic [7:0] out_r, out_g, out_b;
  logic out_de, out_vs, out_hs, err;

  always #2.5 clk = ~clk;

  pix_recirc i_pix_recirc (
    .clk(clk), .rst_n(rst_n), .mode24(mode24),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_de(in_de), .in_vs(in_vs), .in_hs(in_hs),
    .in_seq(in_seq), .in_par(in_par),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_de(out_de), .out_vs(out_vs), .out_hs(out_hs), .err(err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [27:0] exp_w;
  string       exp_tag;
  bit          m_prev_ok, m_started;
  logic [1:0]  m_prev_seq, s;

  function automatic logic [7:0] msk(input bit m24, input logic [7:0] v);
    return m24 ? v : {v[7:2], 2'b00};
  endfunction

  function automatic logic odd_par(input bit m24, input logic [7:0] r, g, b,
                                   input logic de, vs, hs, input logic [1:0] sq);
    logic x;
    x = ^{msk(m24, r), msk(m24, g), msk(m24, b), de, vs, hs, sq};
    return ~x;
  endfunction

  function automatic logic [27:0] outw();
    return {out_r, out_g, out_b, out_de, out_vs, out_hs, err};
  endfunction

  task automatic chk(input string tag, input logic [27:0] got, input logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Applies one payload at a falling edge, after checking the result of the previous one.
  task automatic send(input string tag, input bit m24, input logic [7:0] r, g, b,
                      input logic de, vs, hs, input logic [1:0] sq, input bit bad_par);
    logic pk, pass;
    @(negedge clk);
    chk(exp_tag, outw(), exp_w);
    mode24 = m24; in_r = r; in_g = g; in_b = b;
    in_de = de; in_vs = vs; in_hs = hs; in_seq = sq;
    in_par = odd_par(m24, r, g, b, de, vs, hs, sq) ^ bad_par;
    pk = !bad_par;
    pass = pk && m_prev_ok && (sq == m_prev_seq + 2'd1);
    if (pass) begin
      exp_w = {msk(m24, r), msk(m24, g), msk(m24, b), de, vs, hs, 1'b0};
      m_started = 1;
    end else if (m_started) begin
      exp_w[0] = 1'b1;
    end else begin
      exp_w = '0;
    end
    exp_tag = tag;
    m_prev_ok = pk;
    m_prev_seq = sq;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; mode24 = 1; in_r = 8'hff; in_g = 8'hff; in_b = 8'hff;
    in_de = 1; in_vs = 1; in_hs = 1; in_seq = 2'd3; in_par = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", outw(), 28'h0);
    rst_n = 1;
    m_prev_ok = 0; m_prev_seq = 0; m_started = 0; exp_w = '0; exp_tag = "R6";

    // startup: one good payload alone is not enough
    send("R6", 1, 8'h11, 8'h22, 8'h33, 1, 0, 0, 2'd0, 0);
    send("R4", 1, 8'h12, 8'h23, 8'h34, 1, 0, 1, 2'd1, 0);
    send("R8", 1, 8'hA5, 8'h5A, 8'hC3, 1, 1, 0, 2'd2, 0);
    send("R4", 1, 8'h01, 8'h02, 8'h03, 0, 0, 0, 2'd3, 0);
    send("R4", 1, 8'h04, 8'h05, 8'h06, 1, 0, 0, 2'd0, 0); // wrap 3 -> 0
    // parity error, then one good payload still held, then resume
    send("R2", 1, 8'hEE, 8'hEE, 8'hEE, 0, 1, 1, 2'd1, 1);
    send("R4", 1, 8'h77, 8'h66, 8'h55, 1, 0, 0, 2'd2, 0);
    send("R3", 1, 8'h78, 8'h67, 8'h56, 1, 0, 0, 2'd3, 0);
    // good parity, broken sequence
    send("R5", 1, 8'h99, 8'h88, 8'h77, 0, 1, 0, 2'd1, 0);
    send("R3", 1, 8'h9A, 8'h89, 8'h78, 1, 0, 0, 2'd2, 0);
    // narrow mode: junk in low bits is ignored
    send("R7", 0, 8'hFF, 8'h03, 8'hA6, 1, 0, 1, 2'd3, 0);
    send("R7", 0, 8'hFC, 8'h01, 8'hA5, 1, 0, 1, 2'd0, 0);
    // single flipped bit (parity off) in narrow mode
    send("R1", 0, 8'h40, 8'h00, 8'h00, 1, 0, 0, 2'd1, 1);
    send("R1", 0, 8'h40, 8'h00, 8'h00, 1, 0, 0, 2'd2, 0);
    send("R1", 1, 8'h41, 8'h00, 8'h00, 1, 0, 0, 2'd3, 0);

    s = 2'd3;
    for (int i = 0; i < 3000; i++) begin
      int c;
      bit m;
      bit bp;
      c = $urandom % 20;
      m = ((i / 300) % 2) == 0;
      bp = (c == 0);
      if (c == 1) s = s + 2'd2; else s = s + 2'd1;
      send(bp ? "R2" : (c == 1 ? "R5" : (m ? "R8" : "R7")), m,
           8'($urandom), 8'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), s, bp);
    end
    @(negedge clk);
    chk(exp_tag, outw(), exp_w);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule